// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

The block moves 8-bit characters over a serial data pair timed by a serial clock. The transmitter and receiver run independently, so a character can go out while another comes in. There is one frame format: eight data bits, least significant first, with no start, stop or parity bits. Outgoing data changes on the falling edge of the bit clock, and incoming data is sampled on the rising edge.

The bit clock comes from one of two sources, chosen by `clk_sel_i`.

- **Internal source.** A divider on the system clock produces the bit clock. The block drives it onto the serial clock pin and asserts the pin's output enable. The clock toggles only while a character is being sent, and it rests high otherwise. In this mode the receiver therefore captures only while the block is transmitting.
- **External source.** An outside master supplies the serial clock. The block passes it through a two-flop synchronizer and then detects its edges.

The parallel side has two halves:

- **Transmit.** A ready/valid handshake accepts one character at a time.
- **Receive.** One holding register presents each received character with a valid flag. A sticky overrun flag reports that a character arrived while the previous one had not yet been taken; the new character is discarded.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, `sd_o`=1, `sck_o`=1, `tx_ready_o`=1, `rx_valid_o`=0 and `rx_ovr_o`=0.
- R2: A character is sent least significant bit first. Each bit appears on `sd_o` in the same cycle as a falling edge of the bit clock, and `sd_o` changes in no other cycle except at the end of a character. When the character ends, `sd_o` returns to 1.
- R3: `tx_ready_o` is 1 only while idle. A character is accepted at a rising system-clock edge where `tx_valid_i` and `tx_ready_o` are both 1. `tx_ready_o` returns to 1 in the cycle that the eighth rising bit-clock edge of that character is processed.
- R4: With `clk_sel_i`=0, `sck_oe_o`=1. `sck_o` stays high except while a character is being sent. During a character, each half period lasts `baud_div_i`+1 system cycles. The first fall comes `baud_div_i`+1 cycles after acceptance, and each character has exactly eight low phases.
- R5: The receiver shifts `sd_i` in on every rising bit-clock edge, least significant bit first. After eight such edges it presents the byte on `rx_data_o` with `rx_valid_o`=1 and holds it until a cycle where `rx_ready_i`=1. With the internal source and no transmission, `sd_i` activity produces nothing.
- R6: A character that completes while `rx_valid_o`=1 and is not taken in that cycle is discarded. In that case `rx_data_o` keeps the older byte and `rx_ovr_o` becomes 1. `rx_ovr_o` clears when the held byte is taken.
- R7: With `clk_sel_i`=1, `sck_oe_o`=0 and `sck_o`=1. Edges of `sck_i` are acted on at the third rising system-clock edge after the change.
- R8: With the external source, a character can be sent and a different one received over the same eight clock periods. Each direction delivers its own byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 1 | Bit clock source: 0 internal divider, 1 external pin |
| baud_div_i | input | 8 | Internal half period minus one, in system cycles |
| sck_i | input | 1 | External serial clock |
| sck_o | output | 1 | Serial clock driven by the block |
| sck_oe_o | output | 1 | Output enable for the serial clock pin |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| tx_data_i | input | 8 | Character to send |
| tx_valid_i | input | 1 | Transmit character offered |
| tx_ready_o | output | 1 | Transmitter idle, can accept |
| rx_data_o | output | 8 | Received character |
| rx_valid_o | output | 1 | Received character held |
| rx_ready_i | input | 1 | Consumer takes the held character |
| rx_ovr_o | output | 1 | A character was lost to overrun |

## Verification
The tests use several input patterns:

- **Loopback on the internal source.** Alternating, single-bit and all-ones/all-zeros bytes are sent at two divider settings. Together these separate bit-order faults from half-period counting faults.
- **Data with no transmission.** Toggling `sd_i` while idle on the internal source shows that the receiver follows only the block's own clock.
- **Holding the receiver.** Two characters are sent with the receiver held, which separates discard-on-overrun from overwrite.
- **External source, full duplex.** A slow external clock carries one byte in each direction, which exercises the synchronizer latency and the independence of the two directions.

A behavioural model is compared with every output on every cycle.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
  typedef enum logic {
    CLK_INT = 1'b0,
    CLK_EXT = 1'b1
  } clk_src_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } sck_edge_t;
endpackage

// File: rtl/sxc_baud_gen.sv
module sxc_baud_gen
  import sxc_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output sck_edge_t        edge_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             tick;

  assign tick = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign sck_o       = sck_q;
  assign edge_o.fall = tick & sck_q;
  assign edge_o.rise = tick & ~sck_q;

  // idle clock rests high
  p_idle_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> sck_q);
endmodule

// File: rtl/sxc_sck_sync.sv
module sxc_sck_sync
  import sxc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sck_i,
  output sck_edge_t edge_o
);
  logic [SYNC_STAGES:0] sh_q;
  logic                 cur, old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], sck_i};
  end

  assign cur         = sh_q[SYNC_STAGES-1];
  assign old         = sh_q[SYNC_STAGES];
  assign edge_o.rise = cur & ~old;
  assign edge_o.fall = ~cur & old;
endmodule

// File: rtl/sxc_tx.sv
module sxc_tx
  import sxc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sck_edge_t         edge_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              sd_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              busy_q, half_q, sd_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      sd_q   <= 1'b1;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      half_q <= 1'b0;
      cnt_q  <= '0;
      if (valid_i) begin
        sh_q   <= data_i;
        busy_q <= 1'b1;
      end
    end else if (edge_i.fall) begin
      sd_q   <= sh_q[0];
      sh_q   <= {1'b0, sh_q[DATA_W-1:1]};
      half_q <= 1'b1;
    end else if (edge_i.rise && half_q) begin
      // a rise only counts after this character put a bit out
      half_q <= 1'b0;
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        sd_q   <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign ready_o = ~busy_q;
  assign sd_o    = sd_q;

  p_sd_on_edges_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_i.fall && !edge_i.rise) |=> $stable(sd_q));
  p_idle_line_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> sd_o);
endmodule

// File: rtl/sxc_rx.sv
module sxc_rx
  import sxc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sck_edge_t         edge_i,
  input  logic              sd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              ovr_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, data_q, nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic              valid_q, ovr_q, take, done;

  assign take = valid_q & ready_i;
  assign done = edge_i.rise & (cnt_q == LAST);
  assign nxt  = {sd_i, sh_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (edge_i.rise) begin
      sh_q  <= nxt;
      cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (done && valid_q && !take) ovr_q <= 1'b1;
      else if (take)                ovr_q <= 1'b0;
      if (done && (!valid_q || take)) begin
        data_q  <= nxt;
        valid_q <= 1'b1;
      end else if (take) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign ovr_o   = ovr_q;

  p_hold_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q)));
  p_take_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !ovr_q);
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import sxc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_sel_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sd_i,
  output logic              sd_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              rx_ovr_o
);
  logic      use_ext, int_sck;
  sck_edge_t int_edge, ext_edge, bit_edge;

  assign use_ext = (clk_src_e'(clk_sel_i) == CLK_EXT);

  sxc_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (~tx_ready_o & ~use_ext),
    .div_i (baud_div_i),
    .sck_o (int_sck),
    .edge_o(int_edge)
  );

  sxc_sck_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sck_i (sck_i),
    .edge_o(ext_edge)
  );

  assign bit_edge = use_ext ? ext_edge : int_edge;
  assign sck_o    = use_ext ? 1'b1 : int_sck;
  assign sck_oe_o = ~use_ext;

  sxc_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (bit_edge),
    .data_i (tx_data_i),
    .valid_i(tx_valid_i),
    .ready_o(tx_ready_o),
    .sd_o   (sd_o)
  );

  sxc_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (bit_edge),
    .sd_i   (sd_i),
    .data_o (rx_data_o),
    .valid_o(rx_valid_o),
    .ready_i(rx_ready_i),
    .ovr_o  (rx_ovr_o)
  );
endmodule

// File: tb/sim_sync_serial_xcvr.sv
`timescale 1ns/1ps
module sim_sync_serial_xcvr;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       clk_sel = 1'b0, sck_i = 1'b1, sd_drv = 1'b1, loop = 1'b1;
  logic [7:0] baud_div = 8'd3, tx_data = '0;
  logic       tx_valid = 1'b0, rx_ready = 1'b1;
  logic       sck_o, sck_oe, sd_o, sd_i, tx_ready, rx_valid, rx_ovr;
  logic [7:0] rx_data;
  int         checks = 0, fails = 0, cyc = 0;
  bit         done = 1'b0;
  logic [7:0] got[$];

  always #5 clk = ~clk;
  assign sd_i = loop ? sd_o : sd_drv;

  sync_serial_xcvr u0 (
    .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(clk_sel), .baud_div_i(baud_div),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe), .sd_i(sd_i), .sd_o(sd_o),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .rx_ovr_o(rx_ovr)
  );

  // behavioural reference
  bit       m_busy, m_half, m_sck, m_sd, m_rvld, m_ovr, m_s1, m_s2, m_s3;
  bit       f, r, tick, tk, dn;
  int       m_tmr, m_nbits, m_rn;
  bit [7:0] m_byte, m_rbyte, m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_half = 0; m_sck = 1; m_sd = 1; m_rvld = 0; m_ovr = 0;
      m_s1 = 1; m_s2 = 1; m_s3 = 1; m_tmr = 0; m_nbits = 0; m_rn = 0;
      m_byte = 0; m_rbyte = 0; m_rdata = 0;
    end else begin
      if (!clk_sel) begin
        tick = m_busy && (m_tmr == int'(baud_div));
        f = tick && m_sck; r = tick && !m_sck;
      end else begin
        f = !m_s2 && m_s3; r = m_s2 && !m_s3;
      end
      tk = m_rvld && rx_ready; dn = 0;
      if (r) begin
        m_rbyte[m_rn] = sd_i;
        if (m_rn == 7) begin dn = 1; m_rn = 0; end else m_rn++;
      end
      if (m_busy && !clk_sel) begin
        if (m_tmr == int'(baud_div)) begin m_tmr = 0; m_sck = !m_sck; end
        else m_tmr++;
      end else begin m_tmr = 0; m_sck = 1; end
      if (!m_busy) begin
        m_half = 0; m_nbits = 0;
        if (tx_valid) begin m_byte = tx_data; m_busy = 1; end
      end else if (f) begin
        m_sd = m_byte[m_nbits]; m_half = 1;
      end else if (r && m_half) begin
        m_half = 0; m_nbits++;
        if (m_nbits == 8) begin m_busy = 0; m_sd = 1; end
      end
      if (dn && m_rvld && !tk) m_ovr = 1; else if (tk) m_ovr = 0;
      if (dn && (!m_rvld || tk)) begin m_rdata = m_rbyte; m_rvld = 1; end
      else if (tk) m_rvld = 0;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sck_i;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk(sck_o == (clk_sel ? 1'b1 : m_sck), "R4 sck_o", sck_o, m_sck);
      chk(sck_oe == !clk_sel, "R7 sck_oe", sck_oe, !clk_sel);
      chk(sd_o == m_sd, "R2 sd_o", sd_o, m_sd);
      chk(tx_ready == !m_busy, "R3 tx_ready", tx_ready, !m_busy);
      chk(rx_valid == m_rvld, "R5 rx_valid", rx_valid, m_rvld);
      chk(rx_data == m_rdata, "R5 rx_data", rx_data, m_rdata);
      chk(rx_ovr == m_ovr, "R6 rx_ovr", rx_ovr, m_ovr);
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      chk(0, "watchdog", cyc, 150000);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) if (rst_n && rx_valid && rx_ready) got.push_back(rx_data);

  task automatic send(input logic [7:0] b);
    while (!tx_ready) @(negedge clk);
    tx_data = b; tx_valid = 1; @(negedge clk); tx_valid = 0;
  endtask

  task automatic settle();
    while (!tx_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_got(input logic [7:0] b, input string req);
    if (got.size() == 0) chk(0, req, -1, b);
    else begin
      logic [7:0] g;
      g = got.pop_front();
      chk(g == b, req, g, b);
    end
  endtask

  logic [7:0] txcap;

  task automatic ext_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sck_i = 0; sd_drv = b[i];
      repeat (6) @(negedge clk);
      txcap[i] = sd_o;
      sck_i = 1;
      repeat (6) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sd_o && sck_o && tx_ready && !rx_valid && !rx_ovr, "R1 reset",
        {sd_o, sck_o, tx_ready, rx_valid, rx_ovr}, 5'b11100);

    // R4: first fall baud_div+1 cycles after acceptance
    send(8'hA5);
    repeat (3) @(negedge clk);
    chk(sck_o == 1, "R4 before first fall", sck_o, 1);
    @(negedge clk);
    chk(sck_o == 0 && sd_o == 1'b1, "R4 first fall / R2 lsb", {sck_o, sd_o}, 2'b01);
    send(8'h3C); send(8'h01); send(8'h80);
    settle();
    expect_got(8'hA5, "R5 loop A5"); expect_got(8'h3C, "R5 loop 3C");
    expect_got(8'h01, "R2 loop 01"); expect_got(8'h80, "R2 loop 80");

    baud_div = 8'd0;
    send(8'hFF); send(8'h00);
    settle();
    expect_got(8'hFF, "R4 div0 FF"); expect_got(8'h00, "R4 div0 00");

    // R5: data activity without own clock
    loop = 0;
    for (int i = 0; i < 40; i++) begin sd_drv = ~sd_drv; @(negedge clk); end
    chk(!rx_valid && got.size() == 0, "R5 idle ignore", rx_valid, 0);
    loop = 1;

    // R6: overrun
    baud_div = 8'd2;
    rx_ready = 0;
    send(8'h11); send(8'h22);
    settle();
    chk(rx_valid && rx_data == 8'h11, "R6 keeps old", rx_data, 8'h11);
    chk(rx_ovr == 1, "R6 ovr set", rx_ovr, 1);
    rx_ready = 1; @(negedge clk); rx_ready = 0;
    chk(rx_ovr == 0 && !rx_valid, "R6 ovr cleared", rx_ovr, 0);
    expect_got(8'h11, "R6 taken");
    rx_ready = 1;

    // R7/R8: external clock, full duplex
    loop = 0; clk_sel = 1;
    @(negedge clk);
    chk(sck_oe == 0 && sck_o == 1, "R7 pin released", {sck_oe, sck_o}, 2'b01);
    send(8'hC3);
    repeat (20) @(negedge clk);
    chk(!tx_ready && sd_o == 1, "R7 waits ext clock", {tx_ready, sd_o}, 2'b01);
    ext_byte(8'h6B);
    repeat (4) @(negedge clk);
    chk(tx_ready == 1, "R3 ext done", tx_ready, 1);
    chk(txcap == 8'hC3, "R8 tx byte", txcap, 8'hC3);
    expect_got(8'h6B, "R8 rx byte");

    // back to internal
    sck_i = 1; repeat (4) @(negedge clk);
    clk_sel = 0; loop = 1; baud_div = 8'd5;
    @(negedge clk);
    send(8'h5A);
    settle();
    expect_got(8'h5A, "R5 after ext");

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule